// File: doc/BRIEF.md
# Cartridge Bank Switching Memory Controller

This block sits between a 16-bit CPU address bus and the storage of a cartridge-style memory system. It decodes each CPU access, drives a physical address and an enable to one of four targets (a large banked ROM, a small boot ROM, a banked external RAM and a two-region work RAM), and steers the returned byte back onto the CPU read bus in the same cycle. The storage arrays sit outside the block.

The ROM area cannot be written. A CPU write that lands there is taken as a control command instead. One sub-range arms or disarms the external RAM. A second picks the ROM bank seen in the upper half of the ROM window. A third picks the external RAM bank.

After reset a boot overlay is active. It shadows the start of the ROM with boot ROM contents, except for a gap of 256 bytes. A single boot-disable pulse removes the overlay, and it stays removed until the next reset.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank register holds 1, the RAM bank register holds 0, external RAM is disabled and the boot overlay is active.
- R2: A write to 0x0000–0x1FFF enables external RAM when the data byte is exactly 0x0A. Any other data byte disables it.
- R3: A write to 0x2000–0x3FFF loads the ROM bank. A data byte of 0x00 selects bank 1. Any other byte loads its low 7 bits, so 0x80 selects bank 0.
- R4: A write to 0x4000–0x5FFF loads the RAM bank from data bits [1:0].
- R5: A read of 0x0000–0x3FFF that the boot overlay does not claim asserts `rom_en` with `rom_addr` equal to the CPU address, which is bank 0.
- R6: A read of 0x4000–0x7FFF asserts `rom_en` with `rom_addr` = bank×0x4000 + (addr − 0x4000).
- R7: An access to 0xA000–0xBFFF drives `xram_addr` = RAM bank×0x2000 + (addr − 0xA000). While RAM is enabled, reads return `xram_rdata`. While it is disabled, reads return 0xFF and `xram_en` stays low.
- R8: `xram_we` rises only for a CPU write to 0xA000–0xBFFF while external RAM is enabled.
- R9: While the boot overlay is active, reads of 0x0000–0x00FF and 0x0200–0x08FF assert `boot_en` and return `boot_data`. Reads of 0x0100–0x01FF and of 0x0900 and above go to the ROM.
- R10: A cycle with `boot_off` high clears the boot overlay. It stays cleared whatever `boot_off` does afterwards, until reset.
- R11: 0xC000–0xDFFF asserts `wram_en`. `wram_hi` equals address bit 12, so it is 0 for 0xC000–0xCFFF and 1 for 0xD000–0xDFFF. `wram_addr` equals address bits [11:0], and reads return `wram_rdata`.
- R12: Reads of unmapped addresses (0x8000–0x9FFF, 0xE000–0xFFFF) return 0x00 with no enable raised. A write to 0x6000–0x7FFF changes no bank or enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data returned to CPU |
| boot_off | input | 1 | Removes the boot overlay until reset |
| rom_en | output | 1 | Cartridge ROM read enable |
| rom_addr | output | 21 | Cartridge ROM physical address |
| rom_data | input | 8 | Cartridge ROM read data |
| boot_en | output | 1 | Boot ROM read enable |
| boot_addr | output | 12 | Boot ROM address |
| boot_data | input | 8 | Boot ROM read data |
| xram_en | output | 1 | External RAM enable |
| xram_we | output | 1 | External RAM write enable |
| xram_addr | output | 15 | External RAM physical address |
| xram_rdata | input | 8 | External RAM read data |
| wram_en | output | 1 | Work RAM enable |
| wram_we | output | 1 | Work RAM write enable |
| wram_hi | output | 1 | Work RAM region select |
| wram_addr | output | 12 | Work RAM offset within region |
| wram_rdata | input | 8 | Work RAM read data |

## Verification
The bench checks the boundaries of the boot overlay: 0x00FF against 0x0100, 0x01FF against 0x0200, and 0x08FF against 0x0900. A decoder with an off-by-one or no gap would return boot bytes where cartridge bytes belong. It writes the bank register with 0x00, 0x80 and 0xFF. A design that remapped on the low bits instead of the whole byte, or that failed to mask bit 7, would land in the wrong bank. It writes 0x0B to the RAM arm range and writes to external RAM while it is disarmed. A design that tests a single bit or ignores the arm state would then corrupt RAM or return stale data instead of 0xFF. Finally, it drops `boot_off` after one pulse to catch an overlay that follows the pin instead of latching.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ROM_BANK_BITS = 7,
  parameter int RAM_BANK_BITS = 2,
  parameter int BOOT_AW = 12,
  parameter logic [7:0] RAM_KEY = 8'h0A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [15:0]                 cpu_addr,
  input  logic [7:0]                  cpu_wdata,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  output logic [7:0]                  cpu_rdata,
  input  logic                        boot_off,
  output logic                        rom_en,
  output logic [ROM_BANK_BITS+13:0]   rom_addr,
  input  logic [7:0]                  rom_data,
  output logic                        boot_en,
  output logic [BOOT_AW-1:0]          boot_addr,
  input  logic [7:0]                  boot_data,
  output logic                        xram_en,
  output logic                        xram_we,
  output logic [RAM_BANK_BITS+12:0]   xram_addr,
  input  logic [7:0]                  xram_rdata,
  output logic                        wram_en,
  output logic                        wram_we,
  output logic                        wram_hi,
  output logic [11:0]                 wram_addr,
  input  logic [7:0]                  wram_rdata
);

  logic [ROM_BANK_BITS-1:0] rom_bank;
  logic [RAM_BANK_BITS-1:0] ram_bank;
  logic                     ram_on;
  logic                     boot_on;

  logic [2:0] seg;
  assign seg = cpu_addr[15:13];

  logic in_rom, in_xram, in_wram, in_boot;
  assign in_rom  = ~cpu_addr[15];
  assign in_xram = seg == 3'b101;
  assign in_wram = seg == 3'b110;
  assign in_boot = boot_on &&
                   (cpu_addr < 16'h0100 || (cpu_addr >= 16'h0200 && cpu_addr < 16'h0900));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank <= ROM_BANK_BITS'(1);
      ram_bank <= '0;
      ram_on   <= 1'b0;
      boot_on  <= 1'b1;
    end else begin
      if (boot_off) boot_on <= 1'b0;
      if (cpu_wr) begin
        case (seg)
          3'b000: ram_on <= (cpu_wdata == RAM_KEY);
          3'b001: rom_bank <= (cpu_wdata == 8'h00) ? ROM_BANK_BITS'(1)
                                                   : cpu_wdata[ROM_BANK_BITS-1:0];
          3'b010: ram_bank <= cpu_wdata[RAM_BANK_BITS-1:0];
          default: ;
        endcase
      end
    end
  end

  assign rom_en    = cpu_rd && in_rom && !in_boot;
  assign rom_addr  = cpu_addr[14] ? {rom_bank, cpu_addr[13:0]}
                                  : {{ROM_BANK_BITS{1'b0}}, cpu_addr[13:0]};
  assign boot_en   = cpu_rd && in_boot;
  assign boot_addr = cpu_addr[BOOT_AW-1:0];
  assign xram_en   = (cpu_rd || cpu_wr) && in_xram && ram_on;
  assign xram_we   = cpu_wr && in_xram && ram_on;
  assign xram_addr = {ram_bank, cpu_addr[12:0]};
  assign wram_en   = (cpu_rd || cpu_wr) && in_wram;
  assign wram_we   = cpu_wr && in_wram;
  assign wram_hi   = cpu_addr[12];
  assign wram_addr = cpu_addr[11:0];

  always_comb begin
    if (in_boot)      cpu_rdata = boot_data;
    else if (in_rom)  cpu_rdata = rom_data;
    else if (in_xram) cpu_rdata = ram_on ? xram_rdata : 8'hFF;
    else if (in_wram) cpu_rdata = wram_rdata;
    else              cpu_rdata = 8'h00;
  end

endmodule

module cart_bank_ctrl_chk #(
  parameter int ROM_BANK_BITS = 7,
  parameter int RAM_BANK_BITS = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [15:0]              cpu_addr,
  input logic [7:0]               cpu_wdata,
  input logic                     cpu_rd,
  input logic                     cpu_wr,
  input logic [7:0]               cpu_rdata,
  input logic [ROM_BANK_BITS-1:0] rom_bank,
  input logic [RAM_BANK_BITS-1:0] ram_bank,
  input logic                     ram_on,
  input logic                     boot_on,
  input logic                     rom_en,
  input logic                     boot_en,
  input logic                     xram_en,
  input logic                     xram_we,
  input logic                     wram_en
);

  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata == 8'h0A |=> ram_on);

  a_r2_other_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata != 8'h0A |=> !ram_on);

  a_r3_zero_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata == 8'h00 |=> rom_bank == ROM_BANK_BITS'(1));

  a_r4_ram_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:13] == 3'b010 |=> ram_bank == $past(cpu_wdata[RAM_BANK_BITS-1:0]));

  a_r7_disarmed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr[15:13] == 3'b101 && !ram_on |-> cpu_rdata == 8'hFF);

  a_r8_no_write_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    xram_we |-> ram_on && cpu_wr);

  a_r9_gap_reads_rom: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr[15:8] == 8'h01 |-> rom_en && !boot_en);

  a_r10_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_on |=> !boot_on);

  a_r12_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_en, boot_en, xram_en, wram_en}));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
  .ROM_BANK_BITS(ROM_BANK_BITS),
  .RAM_BANK_BITS(RAM_BANK_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
  .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_on(ram_on), .boot_on(boot_on),
  .rom_en(rom_en), .boot_en(boot_en), .xram_en(xram_en), .xram_we(xram_we),
  .wram_en(wram_en)
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, boot_off = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        rom_en, boot_en, xram_en, xram_we, wram_en, wram_we, wram_hi;
  logic [20:0] rom_addr;
  logic [11:0] boot_addr, wram_addr;
  logic [14:0] xram_addr;

  localparam logic [7:0] ROMD = 8'h5A, BOOTD = 8'hB0, XD = 8'h3C, WD = 8'h77;

  always #5 clk = ~clk;

  cart_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .boot_off(boot_off),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(ROMD),
    .boot_en(boot_en), .boot_addr(boot_addr), .boot_data(BOOTD),
    .xram_en(xram_en), .xram_we(xram_we), .xram_addr(xram_addr), .xram_rdata(XD),
    .wram_en(wram_en), .wram_we(wram_we), .wram_hi(wram_hi), .wram_addr(wram_addr),
    .wram_rdata(WD)
  );

  typedef enum int {K_RDATA, K_ROMA, K_ROMEN, K_BOOTEN, K_XA, K_XEN, K_XWE,
                    K_WEN, K_WHI, K_WA} kind_t;
  typedef struct {
    string       req;
    kind_t       kind;
    logic [31:0] exp;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] actual(kind_t k);
    case (k)
      K_RDATA: return 32'(cpu_rdata);
      K_ROMA:  return 32'(rom_addr);
      K_ROMEN: return 32'(rom_en);
      K_BOOTEN:return 32'(boot_en);
      K_XA:    return 32'(xram_addr);
      K_XEN:   return 32'(xram_en);
      K_XWE:   return 32'(xram_we);
      K_WEN:   return 32'(wram_en);
      K_WHI:   return 32'(wram_hi);
      default: return 32'(wram_addr);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = sb.pop_front();
      a = actual(it.kind);
      checks++;
      if (a !== it.exp) begin
        fails++;
        $display("FAIL %s %s at addr %h: actual %h expected %h",
                 it.req, it.kind.name(), cpu_addr, a, it.exp);
      end
    end
  end

  task automatic put(input logic rd, input logic wr, input logic [15:0] a,
                     input logic [7:0] d);
    @(posedge clk); #1;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic exp(input string req, input kind_t k, input logic [31:0] v);
    item_t it;
    it.req = req; it.kind = k; it.exp = v;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    put(1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [15:0] a);
    put(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1, R9: reset state, overlay
    rd(16'h0000); exp("R1", K_BOOTEN, 1); exp("R9", K_RDATA, BOOTD);
    rd(16'h00FF); exp("R9", K_BOOTEN, 1);
    rd(16'h0100); exp("R9", K_ROMEN, 1); exp("R9", K_RDATA, ROMD); exp("R9", K_ROMA, 32'h100);
    rd(16'h01FF); exp("R9", K_BOOTEN, 0);
    rd(16'h0200); exp("R9", K_BOOTEN, 1);
    rd(16'h08FF); exp("R9", K_BOOTEN, 1); exp("R9", K_RDATA, BOOTD);
    rd(16'h0900); exp("R9", K_ROMEN, 1); exp("R9", K_ROMA, 32'h900);
    rd(16'h4123); exp("R1", K_ROMA, 32'h4123);
    rd(16'hA000); exp("R1", K_RDATA, 8'hFF); exp("R7", K_XEN, 0); exp("R1", K_XA, 32'h0000);

    // R3, R5, R6: ROM banking
    wr(16'h2000, 8'h05);
    rd(16'h4001); exp("R6", K_ROMA, 32'h14001); exp("R6", K_ROMEN, 1);
    rd(16'h3FFF); exp("R5", K_ROMA, 32'h3FFF);
    wr(16'h3FFF, 8'h00);
    rd(16'h4000); exp("R3", K_ROMA, 32'h4000);
    wr(16'h2000, 8'hFF);
    rd(16'h7FFF); exp("R6", K_ROMA, 32'h1FFFFF);
    wr(16'h2000, 8'h80);
    rd(16'h4000); exp("R3", K_ROMA, 32'h0000);
    wr(16'h2000, 8'h09);

    // R2, R4, R7, R8: external RAM
    wr(16'h4000, 8'h07);
    wr(16'h0000, 8'h0B);
    rd(16'hA005); exp("R2", K_RDATA, 8'hFF); exp("R2", K_XEN, 0);
    wr(16'hA006, 8'h11); exp("R8", K_XWE, 0);
    wr(16'h1FFF, 8'h0A);
    rd(16'hA005); exp("R2", K_XEN, 1); exp("R7", K_RDATA, XD); exp("R4", K_XA, 32'h6005);
    wr(16'hA006, 8'h22); exp("R8", K_XWE, 1);
    wr(16'h5FFF, 8'hFE);
    rd(16'hBFFF); exp("R4", K_XA, 32'h5FFF); exp("R7", K_RDATA, XD);
    wr(16'h0000, 8'h00);
    wr(16'hA006, 8'h33); exp("R8", K_XWE, 0); exp("R8", K_XEN, 0);
    rd(16'hB000); exp("R7", K_RDATA, 8'hFF);

    // R12: write to 0x6000 range changes nothing
    wr(16'h6000, 8'h00);
    wr(16'h7FFF, 8'h0A);
    rd(16'h4000); exp("R12", K_ROMA, 32'h24000);
    rd(16'hA001); exp("R12", K_XA, 32'h4001); exp("R12", K_RDATA, 8'hFF);

    // R11: work RAM
    rd(16'hC123); exp("R11", K_WEN, 1); exp("R11", K_WHI, 0);
    exp("R11", K_WA, 32'h123); exp("R11", K_RDATA, WD);
    rd(16'hDFFF); exp("R11", K_WHI, 1); exp("R11", K_WA, 32'hFFF);

    // R12: unmapped reads
    rd(16'h8000); exp("R12", K_RDATA, 0); exp("R12", K_ROMEN, 0);
    rd(16'hE000); exp("R12", K_RDATA, 0); exp("R12", K_WEN, 0);
    rd(16'hFFFF); exp("R12", K_RDATA, 0);

    // R10: boot disable is sticky
    rd(16'h0000); exp("R10", K_BOOTEN, 1);
    @(posedge clk); #1 boot_off = 1'b1;
    @(posedge clk); #1 boot_off = 1'b0;
    rd(16'h0000); exp("R10", K_BOOTEN, 0); exp("R10", K_ROMEN, 1);
    exp("R10", K_RDATA, ROMD); exp("R10", K_ROMA, 32'h0);
    rd(16'h0300); exp("R10", K_BOOTEN, 0);
    rd(16'h0050); exp("R10", K_ROMEN, 1);

    put(1'b0, 1'b0, 16'h0000, 8'h00);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule